// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This unit takes two IEEE-754 operands in either single or double precision and, depending on a 4-bit operation code, produces one of three kinds of answer. The first is a lane-wide truth mask for a packed compare predicate. The second is a 6-bit status word for a scalar compare. The third is the selected operand for a minimum or maximum operation. Each predicate has its own NaN rule. Equality and ordered/unordered tests stay silent when a NaN is present. Less-than style tests report an invalid operation. Minimum and maximum fall back to the second operand.

An invalid-operation mask input decides who handles an invalid condition. When the mask is set, the unit delivers its default answer and raises a sticky-style invalid indication for that result. When the mask is clear, the unit reports a fault and leaves its result and status registers untouched, so that a software handler can supply the answer. All decoding is combinational. One register stage sits at the output, and a valid bit travels alongside the data.

In single precision only bits [31:0] of each operand are examined. Results are zero-extended into the 64-bit output.

Top module: `fpc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_result`, `out_flags`, `out_invalid` and `out_fault` all become zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. All outputs of that transaction appear in the same cycle.
- R3: The mask predicates use these codes: 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered. With ordered operands, a true predicate gives an all-ones lane and a false one gives zero. The lane is 0x00000000FFFFFFFF in single precision and all 64 ones in double precision. +0 and -0 compare equal.
- R4: When either operand is a NaN (quiet or signaling), codes 0 and 7 return zero and codes 3 and 4 return an all-ones lane. None of them raises invalid.
- R5: When either operand is a NaN, codes 1 and 2 return zero and codes 5 and 6 return an all-ones lane. All four raise invalid.
- R6: Codes 8 (signaling) and 9 (quiet) are scalar compares. Their result field is zero. With ordered operands the flags are 6'b000100 for equal, 6'b000001 for a below b, and 6'b000000 for a above b. Bits [5:3] are always zero.
- R7: An unordered scalar compare gives flags 6'b000111. Code 8 raises invalid for any NaN. Code 9 raises invalid only for a signaling NaN, that is, a NaN whose top mantissa bit is 0.
- R8: Code 10 (min) returns a if a < b and b otherwise. Code 11 (max) returns a if a > b and b otherwise. Equal values, including zeros of opposite sign, return b.
- R9: For min and max, if either operand is a NaN, the result is b unchanged (a signaling NaN is not quieted) and invalid is raised.
- R10: `out_invalid` reports the invalid condition of the transaction. If invalid is raised while `inv_mask` is 0, `out_fault` is 1 and `out_result` and `out_flags` keep their previous values. If `inv_mask` is 1, `out_fault` is 0 and the result is written.
- R11: Codes 12 to 15 return a zero result and zero flags and raise no invalid.
- R12: In single precision, operand bits [63:32] have no effect and result bits [63:32] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_op | input | 4 | Operation code (see R3, R6, R8, R11) |
| in_dbl | input | 1 | 1 = double precision, 0 = single |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| inv_mask | input | 1 | 1 = invalid handled by default answer |
| out_valid | output | 1 | Registered result present |
| out_result | output | 64 | Mask, selected operand, or zero |
| out_flags | output | 6 | Scalar compare status |
| out_invalid | output | 1 | Invalid condition of this result |
| out_fault | output | 1 | Unmasked invalid: result not written |

## Verification
The NaN-response logic and the fault gate can act in the same cycle. An unordered operand pair reaches a signaling predicate, a scalar compare or min/max while `inv_mask` is clear. The directed part provokes this right after a transaction whose written result is known. The random part mixes NaN operands with a random mask on every vector. The bench judges each such cycle by requiring `out_fault` and `out_invalid` to be high. It also requires the result and flags to equal the values its own model last saw written, not the default NaN answer.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
// Shared widths, opcode encoding, operand classification record and
// status-flag bit positions for the compare and min/max unit.
package fpc_pkg;
    localparam int DW     = 64;   // datapath width (double precision)
    localparam int SP_W   = 32;   // single precision width
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;
    localparam int FLG_W  = 6;

    // flag bit positions
    localparam int FLG_BELOW = 0;
    localparam int FLG_UNORD = 1;
    localparam int FLG_EQUAL = 2;

    typedef enum logic [3:0] {
        OP_EQ        = 4'd0,
        OP_LT        = 4'd1,
        OP_LE        = 4'd2,
        OP_UNORD     = 4'd3,
        OP_NEQ       = 4'd4,
        OP_NLT       = 4'd5,
        OP_NLE       = 4'd6,
        OP_ORD       = 4'd7,
        OP_SCMP_SIG  = 4'd8,
        OP_SCMP_QUI  = 4'd9,
        OP_MIN       = 4'd10,
        OP_MAX       = 4'd11
    } fpc_op_e;

    typedef struct packed {
        logic          sign;
        logic [DW-2:0] mag;
        logic          zero;
        logic          nan;
        logic          snan;
    } fpc_cls_t;
endpackage

// File: rtl/fpc_unpack.sv
`timescale 1ns/1ps
// Operand classifier: splits one operand into sign and magnitude for the
// selected precision and flags zero, NaN and signaling NaN.
// Assumes single-precision values sit in bits [31:0]; upper bits are ignored then.
module fpc_unpack
    import fpc_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic          dbl,
    output fpc_cls_t      cls
);
    logic exp_ones;
    logic man_nz;
    logic qbit;

    // Pick fields by precision and classify the value.
    always_comb begin
        cls = '0;
        if (dbl) begin
            cls.sign = raw[DW-1];
            cls.mag  = raw[DW-2:0];
            exp_ones = &raw[DW-2 -: DP_EXP];
            man_nz   = |raw[DP_MAN-1:0];
            qbit     = raw[DP_MAN-1];
        end else begin
            cls.sign = raw[SP_W-1];
            cls.mag  = {{(DW-SP_W){1'b0}}, raw[SP_W-2:0]};
            exp_ones = &raw[SP_W-2 -: SP_EXP];
            man_nz   = |raw[SP_MAN-1:0];
            qbit     = raw[SP_MAN-1];
        end
        cls.nan  = exp_ones & man_nz;
        cls.snan = exp_ones & man_nz & ~qbit;
        cls.zero = (cls.mag == '0);
    end
endmodule

// File: rtl/fpc_order.sv
`timescale 1ns/1ps
// Sign-magnitude ordering of two classified operands. Gives equal and
// a-below-b for the non-NaN interpretation; callers mask with the NaN flags.
// Assumes both zeros are equal regardless of sign.
module fpc_order
    import fpc_pkg::*;
(
    input  fpc_cls_t ca,
    input  fpc_cls_t cb,
    output logic     eq,
    output logic     lt
);
    logic mag_lt;

    // Unsigned magnitude comparison shared by both sign cases.
    always_comb mag_lt = (ca.mag < cb.mag);

    // Resolve ordering from signs and magnitudes.
    always_comb begin
        eq = (ca.zero && cb.zero) || ((ca.sign == cb.sign) && (ca.mag == cb.mag));
        if (eq)
            lt = 1'b0;
        else if (ca.sign != cb.sign)
            lt = ca.sign;
        else if (!ca.sign)
            lt = mag_lt;
        else
            lt = !mag_lt;
    end
endmodule

// File: rtl/fpc_select.sv
`timescale 1ns/1ps
// Result builder: turns ordering and NaN information into a predicate mask,
// scalar status flags or a min/max selection, and decides whether the
// operation raises invalid. Assumes opcode encoding from fpc_pkg.
module fpc_select
    import fpc_pkg::*;
(
    input  logic [3:0]       op,
    input  logic             dbl,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             nan_any,
    input  logic             snan_any,
    input  logic             eq,
    input  logic             lt,
    output logic [DW-1:0]    res,
    output logic [FLG_W-1:0] flg,
    output logic             inv
);
    localparam logic [DW-1:0] SP_ONES = {{(DW-SP_W){1'b0}}, {SP_W{1'b1}}};

    logic [DW-1:0]    lane_ones;
    logic [DW-1:0]    lane_a;
    logic [DW-1:0]    lane_b;
    logic             gt;
    logic             hit;
    logic             is_mask;
    logic [FLG_W-1:0] scal_flg;

    // Precision-dependent lane views of the operands and the true mask.
    always_comb begin
        lane_ones = dbl ? '1 : SP_ONES;
        lane_a    = dbl ? a : {{(DW-SP_W){1'b0}}, a[SP_W-1:0]};
        lane_b    = dbl ? b : {{(DW-SP_W){1'b0}}, b[SP_W-1:0]};
        gt        = !eq && !lt;
    end

    // Scalar compare status word.
    always_comb begin
        scal_flg = '0;
        if (nan_any) begin
            scal_flg[FLG_BELOW] = 1'b1;
            scal_flg[FLG_UNORD] = 1'b1;
            scal_flg[FLG_EQUAL] = 1'b1;
        end else begin
            scal_flg[FLG_EQUAL] = eq;
            scal_flg[FLG_BELOW] = lt;
        end
    end

    // Per-opcode predicate, selection and invalid decision.
    always_comb begin
        hit     = 1'b0;
        is_mask = 1'b1;
        inv     = 1'b0;
        res     = '0;
        flg     = '0;
        case (op)
            OP_EQ:    hit = !nan_any && eq;
            OP_ORD:   hit = !nan_any;
            OP_UNORD: hit = nan_any;
            OP_NEQ:   hit = nan_any || !eq;
            OP_LT: begin
                hit = !nan_any && lt;
                inv = nan_any;
            end
            OP_LE: begin
                hit = !nan_any && (lt || eq);
                inv = nan_any;
            end
            OP_NLT: begin
                hit = nan_any || !lt;
                inv = nan_any;
            end
            OP_NLE: begin
                hit = nan_any || gt;
                inv = nan_any;
            end
            OP_SCMP_SIG: begin
                is_mask = 1'b0;
                flg     = scal_flg;
                inv     = nan_any;
            end
            OP_SCMP_QUI: begin
                is_mask = 1'b0;
                flg     = scal_flg;
                inv     = snan_any;
            end
            OP_MIN: begin
                is_mask = 1'b0;
                res     = (!nan_any && lt) ? lane_a : lane_b;
                inv     = nan_any;
            end
            OP_MAX: begin
                is_mask = 1'b0;
                res     = (!nan_any && gt) ? lane_a : lane_b;
                inv     = nan_any;
            end
            default: is_mask = 1'b0;
        endcase
        if (is_mask)
            res = hit ? lane_ones : '0;
    end
endmodule

// File: rtl/fpc_unit.sv
`timescale 1ns/1ps
// Top of the compare and min/max unit: classifies both operands, orders
// them, builds the answer and registers it with a valid bit. An unmasked
// invalid suppresses the result and flag write and raises a fault.
// Assumes one operation per valid cycle; no back-pressure.
module fpc_unit
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic             in_dbl,
    input  logic [DW-1:0]    in_a,
    input  logic [DW-1:0]    in_b,
    input  logic             inv_mask,
    output logic             out_valid,
    output logic [DW-1:0]    out_result,
    output logic [FLG_W-1:0] out_flags,
    output logic             out_invalid,
    output logic             out_fault
);
    localparam int N_OPND = 2;

    logic [DW-1:0]    opnd [N_OPND];
    fpc_cls_t         cls  [N_OPND];
    logic             eq_d, lt_d, nan_any, snan_any;
    logic [DW-1:0]    res_d;
    logic [FLG_W-1:0] flg_d;
    logic             inv_d, fault_d;

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    // One classifier per operand.
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_unpack
        fpc_unpack u_unpack (.raw(opnd[gi]), .dbl(in_dbl), .cls(cls[gi]));
    end

    // Combine NaN classes of the two operands.
    always_comb begin
        nan_any  = cls[0].nan  | cls[1].nan;
        snan_any = cls[0].snan | cls[1].snan;
    end

    fpc_order u_order (.ca(cls[0]), .cb(cls[1]), .eq(eq_d), .lt(lt_d));

    fpc_select u_select (
        .op(in_op), .dbl(in_dbl), .a(in_a), .b(in_b),
        .nan_any(nan_any), .snan_any(snan_any), .eq(eq_d), .lt(lt_d),
        .res(res_d), .flg(flg_d), .inv(inv_d)
    );

    // Fault when invalid is raised with the mask clear.
    always_comb fault_d = inv_d & ~inv_mask;

    // Output register stage; faulting operations leave result and flags untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_flags   <= '0;
            out_invalid <= 1'b0;
            out_fault   <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_invalid <= in_valid & inv_d;
            out_fault   <= in_valid & fault_d;
            if (in_valid && !fault_d) begin
                out_result <= res_d;
                out_flags  <= flg_d;
            end
        end
    end

    // R2: a presented operand set produces a result next cycle
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: no result without an operand set
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: quiet predicates never report invalid
    assert_quiet_pred_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_EQ || in_op == OP_NEQ || in_op == OP_ORD || in_op == OP_UNORD))
        |=> !out_invalid);
    // R5: a NaN reaching a less-than style predicate reports invalid
    assert_nan_signals_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nan_any && (in_op == OP_LT || in_op == OP_NLE)) |=> out_invalid);
    // R6: upper status bits stay clear
    assert_flags_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[FLG_W-1:3] == '0);
    // R10: a fault is always an invalid condition
    assert_fault_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_invalid);
    // R10: a fault leaves result and flags unchanged
    assert_fault_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> ($stable(out_result) && $stable(out_flags)));
endmodule

// File: tb/sim_fpc_unit.sv
`timescale 1ns/1ps
module sim_fpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_dbl = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        inv_mask = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;
    logic        out_invalid;
    logic        out_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [63:0] last_res = '0;
    logic [5:0]  last_flg = '0;

    always #2.5 clk = ~clk;

    fpc_unit u0 (.*);

    function automatic bit is_nan(logic [63:0] x, bit d);
        return d ? (x[62:52] == 11'h7FF && x[51:0] != 0) : (x[30:23] == 8'hFF && x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [63:0] x, bit d);
        return is_nan(x, d) && !(d ? x[51] : x[22]);
    endfunction

    // signed ordering key; both zeros map to 0
    function automatic longint okey(logic [63:0] x, bit d);
        longint m;
        bit s;
        m = d ? longint'({1'b0, x[62:0]}) : longint'({33'b0, x[30:0]});
        s = d ? x[63] : x[31];
        return s ? -m : m;
    endfunction

    function automatic void model(input logic [3:0] op, input bit d, input logic [63:0] a, b,
                                  output logic [63:0] r, output logic [5:0] f, output bit inv);
        longint ka, kb;
        bit nan, snan;
        logic [63:0] ones, av, bv;
        ka = okey(a, d); kb = okey(b, d);
        nan  = is_nan(a, d) || is_nan(b, d);
        snan = is_snan(a, d) || is_snan(b, d);
        ones = d ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        av = d ? a : {32'b0, a[31:0]};
        bv = d ? b : {32'b0, b[31:0]};
        r = '0; f = '0; inv = 1'b0;
        case (op)
            4'd0: r = (!nan && ka == kb) ? ones : 64'd0;
            4'd1: begin r = (!nan && ka < kb) ? ones : 64'd0; inv = nan; end
            4'd2: begin r = (!nan && ka <= kb) ? ones : 64'd0; inv = nan; end
            4'd3: r = nan ? ones : 64'd0;
            4'd4: r = (nan || ka != kb) ? ones : 64'd0;
            4'd5: begin r = (nan || !(ka < kb)) ? ones : 64'd0; inv = nan; end
            4'd6: begin r = (nan || !(ka <= kb)) ? ones : 64'd0; inv = nan; end
            4'd7: r = !nan ? ones : 64'd0;
            4'd8, 4'd9: begin
                f = nan ? 6'b000111 : (ka == kb) ? 6'b000100 : (ka < kb) ? 6'b000001 : 6'b000000;
                inv = (op == 4'd8) ? nan : snan;
            end
            4'd10: begin r = nan ? bv : ((ka < kb) ? av : bv); inv = nan; end
            4'd11: begin r = nan ? bv : ((ka > kb) ? av : bv); inv = nan; end
            default: ;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] op, bit nan);
        if (op <= 4'd7) begin
            if (!nan) return "R3";
            return (op == 4'd1 || op == 4'd2 || op == 4'd5 || op == 4'd6) ? "R5" : "R4";
        end
        if (op <= 4'd9) return nan ? "R7" : "R6";
        if (op <= 4'd11) return nan ? "R9" : "R8";
        return "R11";
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // drive one operation, check its registered outputs one cycle later
    task automatic apply(logic [3:0] op, bit d, logic [63:0] a, logic [63:0] b, bit m, string tag);
        logic [63:0] er;
        logic [5:0]  ef;
        bit ei, ex_fault;
        string rq;
        model(op, d, a, b, er, ef, ei);
        rq = (tag != "") ? tag : req_of(op, is_nan(a, d) || is_nan(b, d));
        @(negedge clk);
        in_op = op; in_dbl = d; in_a = a; in_b = b; inv_mask = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ex_fault = ei && !m;
        chk("R2 out_valid", 64'(out_valid), 64'd1);
        chk({rq, " invalid"}, 64'(out_invalid), 64'(ei));
        chk("R10 fault", 64'(out_fault), 64'(ex_fault));
        if (ex_fault) begin
            chk("R10 held result", out_result, last_res);
            chk("R10 held flags", 64'(out_flags), 64'(last_flg));
        end else begin
            chk({rq, " result"}, out_result, er);
            chk({rq, " flags"}, 64'(out_flags), 64'(ef));
            last_res = er;
            last_flg = ef;
        end
    endtask

    function automatic logic [63:0] gen(bit d, logic [63:0] other);
        logic [63:0] x;
        logic [31:0] r0, r1;
        int sel;
        r0 = $urandom; r1 = $urandom;
        x = {r0, r1};
        sel = $urandom % 8;
        if (d) begin
            case (sel)
                0: x = {r0[0], 63'd0};
                1: x = {r0[0], 11'h7FF, 52'd0};
                2: x = {r0[0], 11'h7FF, 1'b1, r0[18:0], r1};
                3: x = {r0[0], 11'h7FF, 1'b0, r0[18:1], r1 | 32'd1};
                4: x = other;
                default: ;
            endcase
        end else begin
            case (sel)
                0: x = {r0, r1[0], 31'd0};
                1: x = {r0, r1[0], 8'hFF, 23'd0};
                2: x = {r0, r1[31], 8'hFF, 1'b1, r1[21:0]};
                3: x = {r0, r1[31], 8'hFF, 1'b0, r1[21:0] | 22'd1};
                4: x = {r0, other[31:0]};
                default: ;
            endcase
        end
        return x;
    endfunction

    localparam logic [63:0] SP_ONE  = 64'hDEAD_BEEF_3F80_0000;
    localparam logic [63:0] SP_TWO  = 64'h1234_5678_4000_0000;
    localparam logic [63:0] SP_QNAN = 64'h0000_0000_7FC0_0000;
    localparam logic [63:0] SP_SNAN = 64'h0000_0000_7F80_0001;
    localparam logic [63:0] DP_POS0 = 64'h0000_0000_0000_0000;
    localparam logic [63:0] DP_NEG0 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] DP_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] DP_M2   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] DP_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] DP_SNAN = 64'h7FF0_0000_0000_0005;

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_result", out_result, 64'd0);
        chk("R1 out_flags", 64'(out_flags), 64'd0);
        chk("R1 out_invalid", 64'(out_invalid), 64'd0);
        chk("R1 out_fault", 64'(out_fault), 64'd0);
        rst_n = 1'b1;

        // R3: signed zeros equal; single-precision less-than
        apply(4'd0, 1, DP_POS0, DP_NEG0, 1, "R3");
        apply(4'd1, 0, SP_ONE, SP_TWO, 1, "R12");
        apply(4'd5, 0, SP_TWO, SP_ONE, 1, "R12");
        apply(4'd2, 1, DP_M2, DP_ONE, 1, "R3");
        // R2 idle
        @(negedge clk);
        chk("R2 idle out_valid", 64'(out_valid), 64'd0);
        // R4 quiet predicates on NaN, mask clear
        apply(4'd0, 1, DP_SNAN, DP_ONE, 0, "R4");
        apply(4'd4, 0, SP_ONE, SP_QNAN, 0, "R4");
        apply(4'd3, 1, DP_QNAN, DP_ONE, 0, "R4");
        // R5 signaling predicates, masked
        apply(4'd1, 1, DP_QNAN, DP_ONE, 1, "R5");
        apply(4'd6, 0, SP_ONE, SP_SNAN, 1, "R5");
        // R6 ordered scalar compares
        apply(4'd8, 1, DP_ONE, DP_ONE, 1, "R6");
        apply(4'd9, 1, DP_M2, DP_ONE, 1, "R6");
        apply(4'd9, 0, SP_TWO, SP_ONE, 1, "R6");
        // R7 unordered scalar compares
        apply(4'd9, 0, SP_QNAN, SP_ONE, 0, "R7");
        apply(4'd9, 1, DP_ONE, DP_SNAN, 1, "R7");
        apply(4'd8, 1, DP_QNAN, DP_ONE, 1, "R7");
        // R8 min/max with zeros and ordered values
        apply(4'd10, 1, DP_NEG0, DP_POS0, 1, "R8");
        apply(4'd11, 1, DP_POS0, DP_NEG0, 1, "R8");
        apply(4'd11, 0, SP_TWO, SP_ONE, 1, "R8");
        // R9 min/max with NaN
        apply(4'd10, 1, DP_ONE, DP_SNAN, 1, "R9");
        apply(4'd11, 0, SP_QNAN, SP_ONE, 1, "R9");
        // R10 unmasked invalid after a known written result
        apply(4'd4, 1, DP_ONE, DP_M2, 1, "R10");
        apply(4'd1, 1, DP_QNAN, DP_ONE, 0, "R10");
        apply(4'd8, 0, SP_SNAN, SP_ONE, 0, "R10");
        apply(4'd10, 1, DP_ONE, DP_QNAN, 0, "R10");
        // R11 undefined codes
        apply(4'd13, 1, DP_QNAN, DP_ONE, 0, "R11");
        apply(4'd15, 0, SP_ONE, SP_TWO, 1, "R11");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit d;
            logic [63:0] a, b;
            logic [3:0] op;
            d  = $urandom % 2;
            op = 4'($urandom % 13);
            a  = gen(d, 64'($urandom));
            b  = gen(d, a);
            apply(op, d, a, b, bit'($urandom % 2), "");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule